// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a prescaled tick of the system clock. The tick comes from a free-running 17-bit divider, and a three-bit select field picks one of eight divider taps. When the counter wraps from 0xFF to 0x00 it sets a sticky overflow flag.

A mode bit decides what that overflow does. In interval mode the flag is presented as a level interrupt request. In watchdog mode each overflow drives a fixed-length pulse on an external overflow output. Software reaches the block through a small register bus with an address, a read strobe, a write strobe and 16-bit write data. Address 0 is the control/status register and address 1 reads back the counter. A write counts only when its upper byte carries a key value.

The sticky flag is tracked by a three-state machine. The states are FL_CLEAR, FL_PENDING and FL_ARMED, and the transitions are:

- overflow: FL_CLEAR to FL_PENDING, and FL_ARMED to FL_PENDING.
- status read: FL_PENDING to FL_ARMED.
- keyed write with bit 7 = 0: FL_ARMED to FL_CLEAR.
- keyed write with bit 7 = 1: FL_ARMED to FL_PENDING.

The pulse generator has two states, PL_IDLE and PL_ACTIVE:

- watchdog-mode overflow: PL_IDLE to PL_ACTIVE. It also reloads the pulse length while in PL_ACTIVE.
- length used up: PL_ACTIVE to PL_IDLE.

Top module: `wdt_dualmode`

## Requirements
- R1: Select codes 0 to 7 in status bits 2:0 pick a prescaler period N of 2, 64, 128, 512, 2048, 8192, 32768 and 131072 system clocks. After the keyed write that enables counting, the first overflow lands on clock edge N/2+1+255·N, counting that write's edge as edge 0. Later overflows follow every 256·N clocks.
- R2: While enable (status bit 5) is 0, the counter and the prescaler are held at zero and do not advance. The counter value reads back at address 1.
- R3: A counter change from 0xFF to 0x00 sets the overflow flag (status bit 7) on the same edge.
- R4: The flag is cleared only by a keyed write with bit 7 = 0 that follows a status read made while the flag was 1. A write of 1, or a 0-write with no such read before it, leaves the flag set.
- R5: With mode (status bit 6) at 0, irq_o is a level equal to the flag. With mode at 1, irq_o stays low.
- R6: After reset the status register reads 0x10: bits 7:5 and 2:0 are 0, bit 4 reads 1 and bit 3 reads 0. The counter reads 0 and both outputs are low.
- R7: A write changes the register only when the address is 0 and bus_wdata[15:8] is 0xA5. The new fields come from bus_wdata[7:0]. Any other upper byte leaves every field and the flag unchanged.
- R8: In watchdog mode each overflow drives wdog_ovf_o high for exactly 4 clocks, starting on the overflow edge.
- R9: If an overflow falls between the arming status read and the clearing 0-write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 status, 1 counter |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Key byte in bits 15:8, data in bits 7:0 |
| bus_rdata | output | 8 | Combinational read data |
| irq_o | output | 1 | Interval-mode interrupt request level |
| wdog_ovf_o | output | 1 | Watchdog-mode overflow pulse |

## Verification
A wrong prescaler tap or a wrong divider reset shows up as a first overflow at the wrong edge. For code 0 it appears hundreds of cycles late or early, and for code 1 it appears thousands of cycles off. Counter readback exposes such an error within a few ticks. A wrong flag-machine state shows up on irq_o and on status bit 7 on the very next bus access: either the flag clears without arming, or it stays set after a legal clear. A wrong pulse-length count is visible on wdog_ovf_o within five clocks of the overflow.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        FL_CLEAR   = 2'd0,
        FL_PENDING = 2'd1,
        FL_ARMED   = 2'd2
    } flag_state_e;

    typedef enum logic {
        PL_IDLE   = 1'b0,
        PL_ACTIVE = 1'b1
    } pulse_state_e;

    typedef struct packed {
        logic       mode;
        logic       en;
        logic [2:0] cks;
    } wdt_ctrl_t;

    // Divider bit whose rising edge marks one prescaler period for a select code.
    function automatic logic [4:0] tap_index(input logic [2:0] cks);
        logic [4:0] idx;
        unique case (cks)
            3'd0: idx = 5'd0;
            3'd1: idx = 5'd5;
            3'd2: idx = 5'd6;
            3'd3: idx = 5'd8;
            3'd4: idx = 5'd10;
            3'd5: idx = 5'd12;
            3'd6: idx = 5'd14;
            default: idx = 5'd16;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_W = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] cks_i,
    output logic       tick_o
);
    import wdt_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic             tap_prev_q;
    logic             tap_now;

    assign tap_now = div_q[tap_index(cks_i)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= '0;
            tap_prev_q <= 1'b0;
        end else if (!en_i) begin
            div_q      <= '0;
            tap_prev_q <= 1'b0;
        end else begin
            div_q      <= div_q + 1'b1;
            tap_prev_q <= tap_now;
        end
    end

    assign tick_o = en_i && tap_now && !tap_prev_q;

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (div_q == '0));

endmodule

// File: rtl/wdt_upcounter.sv
module wdt_upcounter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = en_i && tick_i && (cnt_q == CNT_MAX);

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_flag_fsm.sv
module wdt_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic rd_stat_i,
    input  logic wr_ok_i,
    input  logic wbit_i,
    output logic flag_o
);
    import wdt_pkg::*;

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (ovf_i) state_d = FL_PENDING;
            end
            FL_PENDING: begin
                if (!ovf_i && rd_stat_i) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (ovf_i)                   state_d = FL_PENDING;
                else if (wr_ok_i && !wbit_i) state_d = FL_CLEAR;
                else if (wr_ok_i)            state_d = FL_PENDING;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q != FL_CLEAR);
    end

    // R3
    set_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> (state_q == FL_PENDING));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FL_CLEAR && !(wr_ok_i && !wbit_i)) |=> (state_q != FL_CLEAR));

    // R4
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_PENDING) |=> (state_q != FL_CLEAR));

    // R9
    rearm_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_ARMED && ovf_i) |=> (state_q == FL_PENDING));

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    import wdt_pkg::*;

    localparam int LEN_W = $clog2(PULSE_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_LOAD = LEN_W'(PULSE_LEN - 1);

    pulse_state_e     state_q, state_d;
    logic [LEN_W-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PL_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            PL_IDLE: begin
                if (fire_i) begin
                    state_d = PL_ACTIVE;
                    left_d  = LEN_LOAD;
                end
            end
            PL_ACTIVE: begin
                if (fire_i) begin
                    left_d = LEN_LOAD;
                end else if (left_q == '0) begin
                    state_d = PL_IDLE;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: state_d = PL_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == PL_ACTIVE);
    end

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o);

    // R8
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o);

endmodule

// File: rtl/wdt_dualmode.sv
module wdt_dualmode #(
    parameter int          CNT_W     = 8,
    parameter int          DIV_W     = 17,
    parameter int          PULSE_LEN = 4,
    parameter logic [7:0]  WR_KEY    = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_o,
    output logic        wdog_ovf_o
);
    import wdt_pkg::*;

    localparam int DATA_W = 8;

    wdt_ctrl_t        ctrl_q;
    logic             wr_ok;
    logic             rd_stat;
    logic             tick;
    logic             ovf_ev;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[4:3];
    assign wr_ok   = bus_wr && !bus_addr && (bus_wdata[15:8] == WR_KEY);
    assign rd_stat = bus_rd && !bus_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok) begin
            ctrl_q.mode <= bus_wdata[6];
            ctrl_q.en   <= bus_wdata[5];
            ctrl_q.cks  <= bus_wdata[2:0];
        end
    end

    wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_q.en),
        .cks_i  (ctrl_q.cks),
        .tick_o (tick)
    );

    wdt_upcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_q.en),
        .tick_i (tick),
        .cnt_o  (cnt),
        .ovf_o  (ovf_ev)
    );

    wdt_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf_ev),
        .rd_stat_i (rd_stat),
        .wr_ok_i   (wr_ok),
        .wbit_i    (bus_wdata[7]),
        .flag_o    (flag)
    );

    wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (ovf_ev && ctrl_q.mode),
        .pulse_o (wdog_ovf_o)
    );

    always_comb begin
        if (bus_addr) bus_rdata = DATA_W'(cnt);
        else          bus_rdata = {flag, ctrl_q.mode, ctrl_q.en, 1'b1, 1'b0, ctrl_q.cks};
    end

    assign irq_o = flag && !ctrl_q.mode;

    // R7
    key_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_ok) |=> $stable(ctrl_q));

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev && !ctrl_q.mode && !wr_ok) |=> irq_o);

    // R5
    wdog_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode && !wr_ok) |=> !irq_o);

endmodule

// File: tb/wdt_dualmode_tb.sv
`timescale 1ns/1ps
module wdt_dualmode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic        wdog_ovf_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    wdt_dualmode u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdog_ovf_o(wdog_ovf_o)
    );

    function automatic int sel_period(input int cks);
        case (cks)
            0: return 2;
            1: return 64;
            2: return 128;
            3: return 512;
            4: return 2048;
            5: return 8192;
            6: return 32768;
            default: return 131072;
        endcase
    endfunction

    function automatic int first_ovf(input int cks);
        int n = sel_period(cks);
        return n / 2 + 1 + 255 * n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] d);
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_stat(output logic [7:0] d);
        @(negedge clk);
        bus_addr = 1'b0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_evt(input bit wd, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!(wd ? wdog_ovf_o : irq_o) && cyc < 40000);
    endtask

    task automatic clear_all();
        logic [7:0] d;
        bus_read_stat(d);
        bus_write(16'hA500);
    endtask

    initial begin
        logic [7:0] d;
        int cyc;
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        peek(1'b0, d); check(d == 8'h10, "R6", "status after reset", d, 8'h10);
        peek(1'b1, d); check(d == 8'h00, "R6", "counter after reset", d, 0);
        check(!irq_o && !wdog_ovf_o, "R6", "outputs after reset", {irq_o, wdog_ovf_o}, 0);

        // R7 wrong key rejected
        bus_write(16'h5A27);
        peek(1'b0, d); check(d == 8'h10, "R7", "bad key ignored", d, 8'h10);

        // R2 counter readback while running, cks 0
        bus_write(16'hA520);
        repeat (10) @(negedge clk);
        peek(1'b1, d); check(d == 8'd5, "R2", "counter after 10 edges", d, 5);
        bus_write(16'hA500);
        repeat (300) @(negedge clk);
        peek(1'b1, d); check(d == 8'd0, "R2", "counter held when disabled", d, 0);

        // R1 R3 R5 first overflow in interval mode, cks 0
        bus_write(16'hA520);
        wait_evt(1'b0, cyc);
        check(cyc == first_ovf(0), "R1", "first overflow edge cks0", cyc, first_ovf(0));
        peek(1'b0, d); check(d[7] == 1'b1, "R3", "flag set", d[7], 1);
        check(irq_o == 1'b1, "R5", "irq level in interval mode", irq_o, 1);

        // R4 write of 1 does not clear, 0-write without read does not clear
        bus_write(16'hA580);
        peek(1'b0, d); check(d == 8'h90, "R4", "write 1 leaves flag", d, 8'h90);
        bus_write(16'hA500);
        peek(1'b0, d); check(d == 8'h90, "R4", "0-write without read leaves flag", d, 8'h90);
        check(irq_o == 1'b1, "R4", "irq still high", irq_o, 1);
        bus_read_stat(d);
        bus_write(16'hA500);
        peek(1'b0, d); check(d == 8'h10, "R4", "read then 0-write clears", d, 8'h10);
        check(irq_o == 1'b0, "R5", "irq drops with flag", irq_o, 0);

        // R9 overflow between arming read and clearing write
        bus_write(16'hA520);
        wait_evt(1'b0, cyc);
        bus_read_stat(d);
        repeat (600) @(negedge clk);
        bus_write(16'hA500);
        peek(1'b0, d); check(d[7] == 1'b1, "R9", "flag kept after intervening overflow", d[7], 1);
        clear_all();
        peek(1'b0, d); check(d == 8'h10, "R9", "clear after re-arm", d, 8'h10);

        // R8 watchdog pulse shape and period, cks 0
        bus_write(16'hA560);
        wait_evt(1'b1, cyc);
        check(cyc == first_ovf(0), "R8", "pulse start edge", cyc, first_ovf(0));
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check(wdog_ovf_o == 1'b1, "R8", "pulse held high", wdog_ovf_o, 1);
        end
        @(negedge clk);
        check(wdog_ovf_o == 1'b0, "R8", "pulse ends after 4", wdog_ovf_o, 0);
        check(irq_o == 1'b0, "R5", "no irq in watchdog mode", irq_o, 0);
        peek(1'b0, d); check(d[7] == 1'b1, "R3", "flag set in watchdog mode", d[7], 1);
        wait_evt(1'b1, cyc);
        check(cyc + 4 == 256 * sel_period(0), "R1", "overflow spacing", cyc + 4, 256 * sel_period(0));
        clear_all();

        // R1 cks 1 interval
        bus_write(16'hA521);
        wait_evt(1'b0, cyc);
        check(cyc == first_ovf(1), "R1", "first overflow edge cks1", cyc, first_ovf(1));
        clear_all();

        // random mix of select code, mode and rejected keys
        for (int i = 0; i < 4; i++) begin
            int cks = $urandom % 2;
            int md = $urandom % 2;
            logic [7:0] key = 8'($urandom);
            logic [7:0] exp_st;
            if (key == 8'hA5) key = 8'hA4;
            bus_write({key, 8'h21});
            peek(1'b0, d); check(d == 8'h10, "R7", "random bad key ignored", d, 8'h10);
            bus_write({8'hA5, 1'b0, 1'(md), 1'b1, 5'(cks)});
            exp_st = {1'b0, 1'(md), 1'b1, 1'b1, 1'b0, 3'(cks)};
            peek(1'b0, d); check(d == exp_st, "R7", "keyed write fields", d, exp_st);
            wait_evt(md != 0, cyc);
            check(cyc == first_ovf(cks), "R1", "random first overflow", cyc, first_ovf(cks));
            clear_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL timeout run hung act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule